// File: doc/BRIEF.md
# Directory Home Controller

This block is the home-node directory of a small shared-memory multiprocessor whose caches talk to memory over point-to-point messages, with no broadcast medium. For every memory block it keeps a directory entry, made of a state (Uncached, Shared or Exclusive) and a sharer vector with one bit per processor, together with the block's data word. Cache controllers send it read misses, write misses and write-backs. It answers each one by updating the entry and sending targeted messages: data replies to the requester, invalidations to sharers, and fetch or fetch-and-invalidate requests to an owner.

The controller serves one request at a time, and messages leave in the order in which they are produced. When the current copy of a block sits in an owner's cache, the controller sends that owner a fetch, drops its request-ready output, and waits on the fetch-response input. The data that comes back is written into the block memory and forwarded to the requester. Invalidations to several sharers go out one per cycle, lowest processor number first.

Top module: `dir_home_ctrl_top`

## Requirements
- R1: After reset `reqReady` is 1, `msgValid` is 0, every block is Uncached with an empty sharer vector, and every block data word is 0.
- R2: A read miss (`reqType`=0) to an Uncached block emits exactly one message, a data reply (`msgType`=3) to the requester carrying the stored word. The block becomes Shared with the requester as its only sharer.
- R3: A write miss (`reqType`=1) to an Uncached block emits exactly one data reply to the requester carrying the stored word. The block becomes Exclusive, owned by the requester.
- R4: A read miss to a Shared block emits exactly one data reply carrying the stored word and adds the requester to the sharers. The state stays Shared.
- R5: A write miss to a Shared block first sends an invalidate (`msgType`=0) to every sharer other than the requester, one per cycle in ascending processor order. In the cycle after the last invalidate it sends a data reply carrying the stored word. The block becomes Exclusive, owned by the requester alone.
- R6: A read miss to an Exclusive block sends a fetch (`msgType`=1) to the owner and waits for `fetchValid`. The returned `fetchData` is written to the block memory and sent as the data reply to the requester. The block becomes Shared, with the old owner and the requester as sharers.
- R7: A write miss to an Exclusive block sends a fetch-and-invalidate (`msgType`=2) to the owner and waits for `fetchValid`. The returned data is written to memory and replied to the requester, which becomes the sole owner. The state stays Exclusive.
- R8: A write-back (`reqType`=2) from the owner of an Exclusive block stores `reqData` into the block memory, empties the sharer vector and makes the block Uncached. No message is sent.
- R9: A write-back to a block that is not Exclusive, a write-back from a processor that is not the owner, and the unused code `reqType`=3 each leave the directory entry and the memory unchanged and send no message.
- R10: `reqReady` falls in the cycle after a request is accepted. It stays low until the request's last message has been issued, including the whole wait for a fetch response, so only one request is ever in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to accept a request |
| reqType | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 unused |
| reqProc | input | PROC_W | Requesting processor number |
| reqAddr | input | ADDR_W | Block index |
| reqData | input | DATA_W | Write-back data |
| fetchValid | input | 1 | Owner's response to a fetch is present |
| fetchData | input | DATA_W | Block data returned by the owner |
| msgValid | output | 1 | Outgoing message present (one cycle each) |
| msgType | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| msgProc | output | PROC_W | Destination processor |
| msgAddr | output | ADDR_W | Block index the message refers to |
| msgData | output | DATA_W | Reply data (0 for other message types) |

## Verification
The bench builds every sharer subset on one block and then lets each processor write-miss it. A design that invalidates the requester itself, skips a sharer, reorders the invalidates or leaves a gap before the reply shows up in the message sequence and in its cycle spacing. Fetch responses arrive after varying delays. A controller that replies with stale memory, forgets to store the fetched word, drops the old owner from the sharers after a remote read, or accepts a request while waiting would give a wrong later reply, a wrong set of later invalidates, or an early ready. A long mixed sequence of requests, including write-backs from non-owners and the unused request code, is then compared message by message against an arithmetic directory model kept in the bench. This catches entries that change when they should not.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    REQ_READ  = 2'd0,
    REQ_WRITE = 2'd1,
    REQ_WBACK = 2'd2,
    REQ_NONE  = 2'd3
  } reqKind_t;

  typedef enum logic [1:0] {
    MSG_INVAL     = 2'd0,
    MSG_FETCH     = 2'd1,
    MSG_FETCH_INV = 2'd2,
    MSG_REPLY     = 2'd3
  } msgKind_t;

  typedef enum logic [1:0] {
    BLK_UNCACHED  = 2'd0,
    BLK_SHARED    = 2'd1,
    BLK_EXCLUSIVE = 2'd2
  } blkState_t;

  typedef enum logic [1:0] {
    SH_KEEP,
    SH_ONLY_REQ,
    SH_ADD_REQ,
    SH_CLEAR
  } sharerOp_t;

  typedef enum logic [1:0] {
    TGT_REQ,
    TGT_OWNER,
    TGT_INVAL
  } target_t;

  typedef enum logic [1:0] {
    MEM_KEEP,
    MEM_FROM_WB,
    MEM_FROM_FETCH
  } memOp_t;

  typedef struct packed {
    logic      latchReq;
    logic      emit;
    msgKind_t  kind;
    target_t   target;
    logic      replyFromFetch;
    logic      stateWr;
    blkState_t newState;
    sharerOp_t sharerOp;
    memOp_t    memOp;
    logic      loadPending;
    logic      popPending;
  } ctrlStrobe_t;

endpackage

// File: rtl/dir_prio_pick.sv
module dir_prio_pick #(
  parameter int WIDTH = 4,
  parameter int IDX_W = 2
) (
  input  logic [WIDTH-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/dir_home_data.sv
module dir_home_data
  import dir_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  parameter int PROC_W     = 2,
  parameter int ADDR_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [1:0]        reqType,
  input  logic [PROC_W-1:0] reqProc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] fetchData,
  output blkState_t         curState,
  output reqKind_t          curKind,
  output logic              pendingAny,
  output logic              reqIsOwner,
  output logic              msgValid,
  output logic [1:0]        msgType,
  output logic [PROC_W-1:0] msgProc,
  output logic [ADDR_W-1:0] msgAddr,
  output logic [DATA_W-1:0] msgData
);
  blkState_t            dirState   [NUM_BLOCKS];
  logic [NUM_PROCS-1:0] dirSharers [NUM_BLOCKS];
  logic [DATA_W-1:0]    blockMem   [NUM_BLOCKS];

  reqKind_t             latKind;
  logic [PROC_W-1:0]    latProc;
  logic [ADDR_W-1:0]    latAddr;
  logic [DATA_W-1:0]    latData;
  logic [NUM_PROCS-1:0] pendVec;

  logic [NUM_PROCS-1:0] curSharers;
  logic [DATA_W-1:0]    curMem;
  logic [NUM_PROCS-1:0] reqOneHot;
  logic [PROC_W-1:0]    ownerIdx;
  logic [PROC_W-1:0]    invalIdx;
  logic                 ownerAny;
  logic [PROC_W-1:0]    targetProc;

  assign curState   = dirState[latAddr];
  assign curSharers = dirSharers[latAddr];
  assign curMem     = blockMem[latAddr];
  assign curKind    = latKind;
  assign reqOneHot  = NUM_PROCS'(1) << latProc;
  assign reqIsOwner = (curState == BLK_EXCLUSIVE) && curSharers[latProc];

  dir_prio_pick #(.WIDTH(NUM_PROCS), .IDX_W(PROC_W)) ownerPick_i (
    .vec(curSharers), .idx(ownerIdx), .any(ownerAny)
  );

  dir_prio_pick #(.WIDTH(NUM_PROCS), .IDX_W(PROC_W)) invalPick_i (
    .vec(pendVec), .idx(invalIdx), .any(pendingAny)
  );

  always_comb begin
    unique case (strobe.target)
      TGT_OWNER: targetProc = ownerAny ? ownerIdx : latProc;
      TGT_INVAL: targetProc = invalIdx;
      default:   targetProc = latProc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        dirState[b]   <= BLK_UNCACHED;
        dirSharers[b] <= '0;
        blockMem[b]   <= '0;
      end
      latKind  <= REQ_NONE;
      latProc  <= '0;
      latAddr  <= '0;
      latData  <= '0;
      pendVec  <= '0;
      msgValid <= 1'b0;
      msgType  <= '0;
      msgProc  <= '0;
      msgAddr  <= '0;
      msgData  <= '0;
    end else begin
      if (strobe.latchReq) begin
        latKind <= reqKind_t'(reqType);
        latProc <= reqProc;
        latAddr <= reqAddr;
        latData <= reqData;
      end

      if (strobe.stateWr) dirState[latAddr] <= strobe.newState;

      unique case (strobe.sharerOp)
        SH_ONLY_REQ: dirSharers[latAddr] <= reqOneHot;
        SH_ADD_REQ:  dirSharers[latAddr] <= curSharers | reqOneHot;
        SH_CLEAR:    dirSharers[latAddr] <= '0;
        default: ;
      endcase

      unique case (strobe.memOp)
        MEM_FROM_WB:    blockMem[latAddr] <= latData;
        MEM_FROM_FETCH: blockMem[latAddr] <= fetchData;
        default: ;
      endcase

      if (strobe.loadPending)
        pendVec <= curSharers & ~reqOneHot;
      else if (strobe.popPending)
        pendVec <= pendVec & ~(NUM_PROCS'(1) << invalIdx);

      msgValid <= strobe.emit;
      if (strobe.emit) begin
        msgType <= strobe.kind;
        msgProc <= targetProc;
        msgAddr <= latAddr;
        if (strobe.kind == MSG_REPLY)
          msgData <= strobe.replyFromFetch ? fetchData : curMem;
        else
          msgData <= '0;
      end else begin
        msgType <= '0;
        msgProc <= '0;
        msgAddr <= '0;
        msgData <= '0;
      end
    end
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        fetchValid,
  input  blkState_t   curState,
  input  reqKind_t    curKind,
  input  logic        pendingAny,
  input  logic        reqIsOwner,
  output logic        reqReady,
  output ctrlStrobe_t strobe
);
  typedef enum logic [1:0] {C_IDLE, C_DECIDE, C_INVAL, C_WAIT} ctrlState_t;

  ctrlState_t state, nextState;

  assign reqReady = (state == C_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= C_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      C_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          nextState       = C_DECIDE;
        end
      end
      C_DECIDE: begin
        nextState = C_IDLE;
        unique case (curKind)
          REQ_READ: begin
            strobe.emit = 1'b1;
            if (curState == BLK_EXCLUSIVE) begin
              strobe.kind   = MSG_FETCH;
              strobe.target = TGT_OWNER;
              nextState     = C_WAIT;
            end else begin
              strobe.kind     = MSG_REPLY;
              strobe.target   = TGT_REQ;
              strobe.stateWr  = 1'b1;
              strobe.newState = BLK_SHARED;
              strobe.sharerOp = (curState == BLK_SHARED) ? SH_ADD_REQ : SH_ONLY_REQ;
            end
          end
          REQ_WRITE: begin
            if (curState == BLK_EXCLUSIVE) begin
              strobe.emit   = 1'b1;
              strobe.kind   = MSG_FETCH_INV;
              strobe.target = TGT_OWNER;
              nextState     = C_WAIT;
            end else if (curState == BLK_SHARED) begin
              strobe.loadPending = 1'b1;
              nextState          = C_INVAL;
            end else begin
              strobe.emit     = 1'b1;
              strobe.kind     = MSG_REPLY;
              strobe.target   = TGT_REQ;
              strobe.stateWr  = 1'b1;
              strobe.newState = BLK_EXCLUSIVE;
              strobe.sharerOp = SH_ONLY_REQ;
            end
          end
          REQ_WBACK: begin
            if (reqIsOwner) begin
              strobe.memOp    = MEM_FROM_WB;
              strobe.sharerOp = SH_CLEAR;
              strobe.stateWr  = 1'b1;
              strobe.newState = BLK_UNCACHED;
            end
          end
          default: ;
        endcase
      end
      C_INVAL: begin
        strobe.emit = 1'b1;
        if (pendingAny) begin
          strobe.kind       = MSG_INVAL;
          strobe.target     = TGT_INVAL;
          strobe.popPending = 1'b1;
        end else begin
          strobe.kind     = MSG_REPLY;
          strobe.target   = TGT_REQ;
          strobe.stateWr  = 1'b1;
          strobe.newState = BLK_EXCLUSIVE;
          strobe.sharerOp = SH_ONLY_REQ;
          nextState       = C_IDLE;
        end
      end
      C_WAIT: begin
        if (fetchValid) begin
          strobe.emit           = 1'b1;
          strobe.kind           = MSG_REPLY;
          strobe.target         = TGT_REQ;
          strobe.replyFromFetch = 1'b1;
          strobe.memOp          = MEM_FROM_FETCH;
          strobe.stateWr        = 1'b1;
          if (curKind == REQ_READ) begin
            strobe.newState = BLK_SHARED;
            strobe.sharerOp = SH_ADD_REQ;
          end else begin
            strobe.newState = BLK_EXCLUSIVE;
            strobe.sharerOp = SH_ONLY_REQ;
          end
          nextState = C_IDLE;
        end
      end
      default: nextState = C_IDLE;
    endcase
  end
endmodule

// File: rtl/dir_home_ctrl_top.sv
module dir_home_ctrl_top
  import dir_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  localparam int PROC_W    = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1,
  localparam int ADDR_W    = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqType,
  input  logic [PROC_W-1:0] reqProc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              fetchValid,
  input  logic [DATA_W-1:0] fetchData,
  output logic              msgValid,
  output logic [1:0]        msgType,
  output logic [PROC_W-1:0] msgProc,
  output logic [ADDR_W-1:0] msgAddr,
  output logic [DATA_W-1:0] msgData
);
  ctrlStrobe_t strobe;
  blkState_t   curState;
  reqKind_t    curKind;
  logic        pendingAny;
  logic        reqIsOwner;

  dir_home_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .fetchValid(fetchValid),
    .curState(curState), .curKind(curKind), .pendingAny(pendingAny),
    .reqIsOwner(reqIsOwner), .reqReady(reqReady), .strobe(strobe)
  );

  dir_home_data #(
    .NUM_PROCS(NUM_PROCS), .NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W),
    .PROC_W(PROC_W), .ADDR_W(ADDR_W)
  ) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqType(reqType),
    .reqProc(reqProc), .reqAddr(reqAddr), .reqData(reqData),
    .fetchData(fetchData), .curState(curState), .curKind(curKind),
    .pendingAny(pendingAny), .reqIsOwner(reqIsOwner), .msgValid(msgValid),
    .msgType(msgType), .msgProc(msgProc), .msgAddr(msgAddr), .msgData(msgData)
  );
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
  parameter int PROC_W = 2,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [PROC_W-1:0] reqProc,
  input logic              fetchValid,
  input logic [DATA_W-1:0] fetchData,
  input logic              msgValid,
  input logic [1:0]        msgType,
  input logic [PROC_W-1:0] msgProc,
  input logic [DATA_W-1:0] msgData
);
  logic [PROC_W-1:0] lastProc;
  logic              fetchPend;
  logic              fetchSeen;
  logic              replySeen;
  logic              fetchWaiting;

  assign fetchSeen    = msgValid && (msgType == 2'd1 || msgType == 2'd2);
  assign replySeen    = msgValid && (msgType == 2'd3);
  assign fetchWaiting = fetchPend || fetchSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastProc  <= '0;
      fetchPend <= 1'b0;
    end else begin
      if (reqValid && reqReady) lastProc <= reqProc;
      if (replySeen)      fetchPend <= 1'b0;
      else if (fetchSeen) fetchPend <= 1'b1;
    end
  end

  // R10
  accept_then_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R10
  fetch_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchSeen |-> !reqReady);

  // R5
  inval_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgType == 2'd0 && $past(msgValid && msgType == 2'd0))
      |-> (msgProc > $past(msgProc)));

  // R2
  reply_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    replySeen |-> (msgProc == lastProc));

  // R6
  fetch_forward_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchWaiting)
      |=> (msgValid && msgType == 2'd3 && msgData == $past(fetchData)));
endmodule

bind dir_home_ctrl_top dir_home_chk #(.PROC_W(PROC_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqProc(reqProc), .fetchValid(fetchValid), .fetchData(fetchData),
  .msgValid(msgValid), .msgType(msgType), .msgProc(msgProc), .msgData(msgData)
);

// File: tb/dir_home_ctrl_top_tb_top.sv
module dir_home_ctrl_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NB = 8;
  localparam int DW = 16;
  localparam int PW = 2;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [1:0]    reqType = '0;
  logic [PW-1:0] reqProc = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic          fetchValid = 1'b0;
  logic [DW-1:0] fetchData = '0;
  logic          msgValid;
  logic [1:0]    msgType;
  logic [PW-1:0] msgProc;
  logic [AW-1:0] msgAddr;
  logic [DW-1:0] msgData;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dir_home_ctrl_top #(.NUM_PROCS(NP), .NUM_BLOCKS(NB), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqType(reqType), .reqProc(reqProc), .reqAddr(reqAddr), .reqData(reqData),
    .fetchValid(fetchValid), .fetchData(fetchData), .msgValid(msgValid),
    .msgType(msgType), .msgProc(msgProc), .msgAddr(msgAddr), .msgData(msgData)
  );

  int nCheck = 0;
  int nFail = 0;

  // bench model: 0 uncached, 1 shared, 2 exclusive
  int          refState [NB];
  logic [NP-1:0] refSh  [NB];
  int          refMem   [NB];

  int expKind [16];
  int expProc [16];
  int expData [16];
  int nExp;
  int actKind [16];
  int actProc [16];
  int actAddr [16];
  int actData [16];
  int actCyc  [16];
  int nAct;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nCheck++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int lowestOf(input logic [NP-1:0] v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic pushExp(input int k, input int p, input int d);
    expKind[nExp] = k;
    expProc[nExp] = p;
    expData[nExp] = d;
    nExp++;
  endtask

  task automatic runReq(input int k, input int p, input int a, input int d,
                        input int fd, input int fdelay);
    string tag;
    int cyc;
    int countdown;
    bit done;
    nExp = 0;
    tag = "R9";
    if (k == 0) begin
      if (refState[a] == 2) begin
        tag = "R6";
        pushExp(1, lowestOf(refSh[a]), 0);
        pushExp(3, p, fd);
        refMem[a] = fd;
        refSh[a][p] = 1'b1;
        refState[a] = 1;
      end else begin
        tag = (refState[a] == 1) ? "R4" : "R2";
        pushExp(3, p, refMem[a]);
        if (refState[a] == 1) refSh[a][p] = 1'b1;
        else refSh[a] = NP'(1) << p;
        refState[a] = 1;
      end
    end else if (k == 1) begin
      if (refState[a] == 2) begin
        tag = "R7";
        pushExp(2, lowestOf(refSh[a]), 0);
        pushExp(3, p, fd);
        refMem[a] = fd;
      end else if (refState[a] == 1) begin
        tag = "R5";
        for (int i = 0; i < NP; i++) if (refSh[a][i] && i != p) pushExp(0, i, 0);
        pushExp(3, p, refMem[a]);
      end else begin
        tag = "R3";
        pushExp(3, p, refMem[a]);
      end
      refSh[a] = NP'(1) << p;
      refState[a] = 2;
    end else if (k == 2 && refState[a] == 2 && refSh[a][p]) begin
      tag = "R8";
      refMem[a] = d;
      refSh[a] = '0;
      refState[a] = 0;
    end

    @(negedge clk);
    reqValid = 1'b1;
    reqType  = 2'(k);
    reqProc  = PW'(p);
    reqAddr  = AW'(a);
    reqData  = DW'(d);
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R10", "ready after accept", int'(reqReady), 0);
    nAct = 0;
    cyc = 0;
    countdown = -1;
    done = 0;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (fetchValid) fetchValid = 1'b0;
      if (msgValid && nAct < 16) begin
        actKind[nAct] = int'(msgType);
        actProc[nAct] = int'(msgProc);
        actAddr[nAct] = int'(msgAddr);
        actData[nAct] = int'(msgData);
        actCyc[nAct]  = cyc;
        nAct++;
        if (msgType == 2'd1 || msgType == 2'd2) countdown = fdelay;
      end
      if (countdown == 0) begin
        check(reqReady == 1'b0, "R10", "ready while fetch outstanding", int'(reqReady), 0);
        fetchValid = 1'b1;
        fetchData  = DW'(fd);
      end
      if (countdown >= 0) countdown--;
      if (reqReady) done = 1;
    end
    check(done, tag, "request completion", int'(done), 1);
    check(nAct == nExp, tag, "message count", nAct, nExp);
    for (int i = 0; i < nAct && i < nExp; i++) begin
      check(actKind[i] == expKind[i], tag, "message type", actKind[i], expKind[i]);
      check(actProc[i] == expProc[i], tag, "message target", actProc[i], expProc[i]);
      check(actAddr[i] == a, tag, "message block", actAddr[i], a);
      if (expKind[i] == 3)
        check(actData[i] == expData[i], tag, "reply data", actData[i], expData[i]);
      if (tag == "R5" && i > 0)
        check(actCyc[i] == actCyc[i-1] + 1, "R5", "message spacing", actCyc[i] - actCyc[i-1], 1);
    end
  endtask

  task automatic makeUncached(input int a);
    if (refState[a] == 1) runReq(1, lowestOf(refSh[a]), a, 0, 0, 0);
    if (refState[a] == 2) runReq(2, lowestOf(refSh[a]), a, 16'h7E00 + a, 0, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nCheck++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] lfsr;
    for (int b = 0; b < NB; b++) begin
      refState[b] = 0;
      refSh[b] = '0;
      refMem[b] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "ready after reset", int'(reqReady), 1);
    check(msgValid == 1'b0, "R1", "no message after reset", int'(msgValid), 0);

    // R1: every block reads back zero on its first read miss
    for (int b = 0; b < NB; b++) runReq(0, b % NP, b, 0, 0, 0);

    // R9: non-owner write-back and the unused code leave everything alone
    runReq(2, 3, 0, 16'hDEAD, 0, 0);
    runReq(3, 1, 0, 16'hBEEF, 0, 0);
    runReq(1, 2, 0, 0, 0, 0);
    runReq(2, 1, 0, 16'h1111, 0, 0);
    runReq(2, 2, 0, 16'h2222, 0, 0);
    runReq(2, 2, 0, 16'h3333, 0, 0);
    runReq(0, 0, 0, 0, 0, 0);

    // R5, R6, R7: every sharer subset against every requester
    for (int s = 0; s < (1 << NP); s++) begin
      for (int p = 0; p < NP; p++) begin
        makeUncached(5);
        for (int i = 0; i < NP; i++) if (s[i]) runReq(0, i, 5, 0, 0, 0);
        runReq(1, p, 5, 0, 0, 0);
        runReq(0, (p + 1) % NP, 5, 0, 16'hA000 + s * 16 + p, s % 3);
        runReq(1, (p + 2) % NP, 5, 0, 0, 0);
        runReq(1, (p + 3) % NP, 5, 0, 16'hB000 + s * 16 + p, p % 3);
        runReq(2, (p + 3) % NP, 5, 16'hC000 + s * 16 + p, 0, 0);
      end
    end

    // mixed sequence over a few contended blocks
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      runReq(int'(lfsr[1:0]), int'(lfsr[3:2]), int'(lfsr[5:4]),
             int'(lfsr) ^ 16'h0F0F, 16'h4000 + n, int'(lfsr[7:6]) % 3);
    end
    summary();
  end
endmodule